// File: doc/BRIEF.md
# 100 Mb/s Nibble to Five-Bit Block Codec

This block sits between a 4-bit nibble interface of the kind used by a media-independent interface and a 5-bit code-group interface facing the line side. On the transmit side it turns each nibble of a frame into a 5-bit code group. It overwrites the first two nibbles of every frame with a start delimiter pair. When the frame ends it appends an end delimiter pair, and it fills the gaps between frames with Idle. The receive side hunts for the start delimiter pair and turns the code groups that follow back into nibbles with a data-valid flag. It flags groups that carry no meaning inside a frame, and it closes the frame on the end delimiter pair or on a run of Idle.

The transmit path is a state machine with four states. TX_IDLE sends Idle and moves to TX_SEND_K when transmit enable is seen, sending J in that same step. TX_SEND_K sends K and moves to TX_DATA. TX_DATA sends encoded nibbles, or Halt when an error is requested, and moves to TX_SEND_R when enable falls, sending T in that step. TX_SEND_R sends R and returns to TX_IDLE.

The receive machine has five states. RX_HUNT moves to RX_SAW_J on J. RX_SAW_J moves to RX_FRAME on K, stays on J, and otherwise falls back to RX_HUNT. RX_FRAME decodes data, moves to RX_SAW_T on T and to RX_SAW_IDLE on Idle. RX_SAW_T always returns to RX_HUNT. RX_SAW_IDLE returns to RX_HUNT on a second Idle, to RX_SAW_T on T, and to RX_FRAME otherwise. When coding is bypassed, either by a configuration bit or by a strap pin, both machines are held in their idle state and the raw 5-bit values pass straight through.

Top module: `pcs_4b5b_codec`

## Requirements
- R1: After reset, tx_code is Idle (11111) and rx_dv, rx_er and rx_early_end are 0.
- R2: While no frame is being sent and bypass is off, tx_code carries Idle (11111) on every cycle.
- R3: In the cycle after tx_en is first sampled high, tx_code is J (11000). In the next cycle it is K (10001). These two groups replace the first two nibbles of the frame, and tx_er has no effect on them.
- R4: Every later nibble sampled with tx_en high appears on tx_code one cycle later with this code: 0=11110 1=01001 2=10100 3=10101 4=01010 5=01011 6=01110 7=01111 8=10010 9=10011 A=10110 B=10111 C=11010 D=11011 E=11100 F=11101.
- R5: In the first cycle in which tx_en is sampled low after the data phase, tx_code becomes T (01101) one cycle later. R (00111) follows in the cycle after that, and Idle follows R.
- R6: A data-phase nibble sampled with tx_er high is sent as Halt (00100) in place of its code group.
- R7: The receiver opens a frame only on J (11000) immediately followed by K (10001). Each data group after that gives rx_dv=1 and the decoded rx_nib one cycle after the group is sampled. J and K themselves give rx_dv=0.
- R8: Inside a frame, T (01101) makes rx_dv 0 and closes the frame. Data groups that follow are ignored (rx_dv=0) until a new J/K pair arrives. If the group after T is not R (00111), rx_er is 1 for that one cycle.
- R9: Inside a frame, any group that is not a data group, T or Idle (Halt, J, K and R included) gives rx_er=1 with rx_dv held at 1 for that cycle.
- R10: An Idle inside a frame gives rx_dv=0. A second consecutive Idle closes the frame and pulses rx_early_end for one cycle.
- R11: Coding is bypassed when cfg_bypass or strap_bypass is 1. In bypass, tx_code equals tx_raw one cycle later, rx_dv, rx_er and rx_early_end are 0, and both framing machines are returned to idle.
- R12: rx_raw always equals rx_code delayed by one cycle, with or without bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bypass | input | 1 | Coding bypass from a control register bit |
| strap_bypass | input | 1 | Coding bypass from a strap pin |
| tx_en | input | 1 | Transmit frame enable |
| tx_er | input | 1 | Transmit error request, sends Halt |
| tx_nib | input | 4 | Transmit data nibble |
| tx_raw | input | 5 | Raw transmit group used in bypass |
| tx_code | output | 5 | Transmitted code group |
| rx_code | input | 5 | Received code group |
| rx_raw | output | 5 | Received group delayed one cycle |
| rx_nib | output | 4 | Decoded receive nibble |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error for this cycle |
| rx_early_end | output | 1 | Frame closed by Idle without T/R |

## Verification
The transmit and receive machines share the clock but no state, so a transmit frame can close with T/R in the very cycle that the receiver flags an invalid group or ends a frame early. The bench provokes this by running a transmit frame and a faulty receive frame as parallel processes, driven on the same falling edges. It then judges each side against its own expected per-cycle list. Bypass raised in the middle of a frame is a second collision, and the bench checks that both machines come back through their idle states and that no delimiter leaks out.

// File: rtl/pcs_codec_pkg.sv
package pcs_codec_pkg;

    localparam int SYM_W   = 5;
    localparam int NIB_W   = 4;
    localparam int NIB_CNT = 1 << NIB_W;

    typedef logic [SYM_W-1:0] sym_t;
    typedef logic [NIB_W-1:0] nib_t;

    localparam sym_t SYM_IDLE = 5'b11111;
    localparam sym_t SYM_J    = 5'b11000;
    localparam sym_t SYM_K    = 5'b10001;
    localparam sym_t SYM_T    = 5'b01101;
    localparam sym_t SYM_R    = 5'b00111;
    localparam sym_t SYM_HALT = 5'b00100;

    typedef struct packed {
        logic hit;
        nib_t nib;
    } dec_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SEND_K,
        TX_DATA,
        TX_SEND_R
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_HUNT,
        RX_SAW_J,
        RX_FRAME,
        RX_SAW_T,
        RX_SAW_IDLE
    } rx_state_e;

    function automatic sym_t enc_nib(nib_t n);
        sym_t s;
        unique case (n)
            4'h0: s = 5'b11110;
            4'h1: s = 5'b01001;
            4'h2: s = 5'b10100;
            4'h3: s = 5'b10101;
            4'h4: s = 5'b01010;
            4'h5: s = 5'b01011;
            4'h6: s = 5'b01110;
            4'h7: s = 5'b01111;
            4'h8: s = 5'b10010;
            4'h9: s = 5'b10011;
            4'hA: s = 5'b10110;
            4'hB: s = 5'b10111;
            4'hC: s = 5'b11010;
            4'hD: s = 5'b11011;
            4'hE: s = 5'b11100;
            4'hF: s = 5'b11101;
            default: s = SYM_IDLE;
        endcase
        return s;
    endfunction

    // Reverse lookup built by searching the forward table.
    function automatic dec_t dec_sym(sym_t s);
        dec_t r;
        r.hit = 1'b0;
        r.nib = '0;
        for (int i = 0; i < NIB_CNT; i++) begin
            if (s == enc_nib(nib_t'(i))) begin
                r.hit = 1'b1;
                r.nib = nib_t'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pcs_tx_encoder.sv
module pcs_tx_encoder
    import pcs_codec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass,
    input  logic             tx_en,
    input  logic             tx_er,
    input  logic [NIB_W-1:0] tx_nib,
    input  logic [SYM_W-1:0] tx_raw,
    output logic [SYM_W-1:0] tx_code
);

    tx_state_e state_q, state_d;
    sym_t      code_q, code_d;

    always_comb begin
        state_d = state_q;
        code_d  = SYM_IDLE;
        if (bypass) begin
            state_d = TX_IDLE;
            code_d  = tx_raw;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    if (tx_en) begin
                        code_d  = SYM_J;
                        state_d = TX_SEND_K;
                    end
                end
                TX_SEND_K: begin
                    code_d  = SYM_K;
                    state_d = TX_DATA;
                end
                TX_DATA: begin
                    if (tx_en) begin
                        code_d = tx_er ? SYM_HALT : enc_nib(tx_nib);
                    end else begin
                        code_d  = SYM_T;
                        state_d = TX_SEND_R;
                    end
                end
                TX_SEND_R: begin
                    code_d  = SYM_R;
                    state_d = TX_IDLE;
                end
                default: state_d = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= SYM_IDLE;
        else        code_q <= code_d;
    end

    assign tx_code = code_q;

    // R3
    tx_k_after_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == SYM_J && state_q == TX_SEND_K && !bypass) |=> (code_q == SYM_K));

    // R5
    tx_r_after_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == SYM_T && state_q == TX_SEND_R && !bypass) |=> (code_q == SYM_R));

    // R2
    tx_idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_IDLE && !tx_en && !bypass) |=> (code_q == SYM_IDLE));

    // R11
    tx_bypass_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> (code_q == $past(tx_raw)));

endmodule

// File: rtl/pcs_rx_decoder.sv
module pcs_rx_decoder
    import pcs_codec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass,
    input  logic [SYM_W-1:0] rx_code,
    output logic [SYM_W-1:0] rx_raw,
    output logic [NIB_W-1:0] rx_nib,
    output logic             rx_dv,
    output logic             rx_er,
    output logic             rx_early_end
);

    rx_state_e state_q, state_d;
    dec_t      dec;
    logic      dv_d, er_d, ee_d;
    nib_t      nib_d;
    logic      dv_q, er_q, ee_q;
    nib_t      nib_q;
    sym_t      raw_q;

    assign dec = dec_sym(rx_code);

    always_comb begin
        state_d = state_q;
        dv_d    = 1'b0;
        er_d    = 1'b0;
        ee_d    = 1'b0;
        nib_d   = '0;
        if (bypass) begin
            state_d = RX_HUNT;
        end else begin
            unique case (state_q)
                RX_HUNT: begin
                    if (rx_code == SYM_J) state_d = RX_SAW_J;
                end
                RX_SAW_J: begin
                    if (rx_code == SYM_K)      state_d = RX_FRAME;
                    else if (rx_code == SYM_J) state_d = RX_SAW_J;
                    else                       state_d = RX_HUNT;
                end
                RX_FRAME: begin
                    if (dec.hit) begin
                        dv_d  = 1'b1;
                        nib_d = dec.nib;
                    end else if (rx_code == SYM_T) begin
                        state_d = RX_SAW_T;
                    end else if (rx_code == SYM_IDLE) begin
                        state_d = RX_SAW_IDLE;
                    end else begin
                        dv_d = 1'b1;
                        er_d = 1'b1;
                    end
                end
                RX_SAW_T: begin
                    state_d = RX_HUNT;
                    er_d    = (rx_code != SYM_R);
                end
                RX_SAW_IDLE: begin
                    if (rx_code == SYM_IDLE) begin
                        state_d = RX_HUNT;
                        ee_d    = 1'b1;
                    end else if (dec.hit) begin
                        state_d = RX_FRAME;
                        dv_d    = 1'b1;
                        nib_d   = dec.nib;
                    end else if (rx_code == SYM_T) begin
                        state_d = RX_SAW_T;
                    end else begin
                        state_d = RX_FRAME;
                        dv_d    = 1'b1;
                        er_d    = 1'b1;
                    end
                end
                default: state_d = RX_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_HUNT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv_q  <= 1'b0;
            er_q  <= 1'b0;
            ee_q  <= 1'b0;
            nib_q <= '0;
            raw_q <= SYM_IDLE;
        end else begin
            dv_q  <= dv_d;
            er_q  <= er_d;
            ee_q  <= ee_d;
            nib_q <= nib_d;
            raw_q <= rx_code;
        end
    end

    assign rx_dv        = dv_q;
    assign rx_er        = er_q;
    assign rx_early_end = ee_q;
    assign rx_nib       = nib_q;
    assign rx_raw       = raw_q;

    // R11
    rx_bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> (!rx_dv && !rx_er && !rx_early_end));

    // R10
    rx_early_end_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_early_end |-> (!rx_dv && state_q == RX_HUNT));

    // R7
    rx_hunt_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_HUNT || state_q == RX_SAW_J) |=> !rx_dv);

    // R12
    rx_raw_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rx_raw == $past(rx_code)));

endmodule

// File: rtl/pcs_4b5b_codec.sv
module pcs_4b5b_codec
    import pcs_codec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_bypass,
    input  logic             strap_bypass,
    input  logic             tx_en,
    input  logic             tx_er,
    input  logic [NIB_W-1:0] tx_nib,
    input  logic [SYM_W-1:0] tx_raw,
    output logic [SYM_W-1:0] tx_code,
    input  logic [SYM_W-1:0] rx_code,
    output logic [SYM_W-1:0] rx_raw,
    output logic [NIB_W-1:0] rx_nib,
    output logic             rx_dv,
    output logic             rx_er,
    output logic             rx_early_end
);

    logic coding_off;

    // Either source alone disables coding.
    assign coding_off = cfg_bypass | strap_bypass;

    pcs_tx_encoder u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .bypass  (coding_off),
        .tx_en   (tx_en),
        .tx_er   (tx_er),
        .tx_nib  (tx_nib),
        .tx_raw  (tx_raw),
        .tx_code (tx_code)
    );

    pcs_rx_decoder u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .bypass       (coding_off),
        .rx_code      (rx_code),
        .rx_raw       (rx_raw),
        .rx_nib       (rx_nib),
        .rx_dv        (rx_dv),
        .rx_er        (rx_er),
        .rx_early_end (rx_early_end)
    );

endmodule

// File: tb/pcs_4b5b_codec_tb.sv
module pcs_4b5b_codec_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_bypass = 1'b0;
    logic       strap_bypass = 1'b0;
    logic       tx_en = 1'b0;
    logic       tx_er = 1'b0;
    logic [3:0] tx_nib = '0;
    logic [4:0] tx_raw = '0;
    logic [4:0] tx_code;
    logic [4:0] rx_code = 5'b11111;
    logic [4:0] rx_raw;
    logic [3:0] rx_nib;
    logic       rx_dv, rx_er, rx_early_end;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [4:0] C_IDLE = 5'b11111;
    localparam logic [4:0] C_J    = 5'b11000;
    localparam logic [4:0] C_K    = 5'b10001;
    localparam logic [4:0] C_T    = 5'b01101;
    localparam logic [4:0] C_R    = 5'b00111;
    localparam logic [4:0] C_HALT = 5'b00100;

    always #4 clk = ~clk;

    pcs_4b5b_codec u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_bypass(cfg_bypass), .strap_bypass(strap_bypass),
        .tx_en(tx_en), .tx_er(tx_er), .tx_nib(tx_nib), .tx_raw(tx_raw), .tx_code(tx_code),
        .rx_code(rx_code), .rx_raw(rx_raw), .rx_nib(rx_nib), .rx_dv(rx_dv),
        .rx_er(rx_er), .rx_early_end(rx_early_end)
    );

    function automatic logic [4:0] exp_enc(logic [3:0] n);
        logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                               5'b01010, 5'b01011, 5'b01110, 5'b01111,
                               5'b10010, 5'b10011, 5'b10110, 5'b10111,
                               5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    function automatic bit is_data(logic [4:0] c);
        for (int i = 0; i < 16; i++) if (exp_enc(4'(i)) == c) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tx_chk(logic [4:0] exp, string tag);
        chk(tx_code === exp, tag, 32'(tx_code), 32'(exp));
    endtask

    // One receive cycle: apply a group, then compare the registered outputs.
    task automatic rx_step(logic [4:0] c, bit dv, logic [3:0] nib, bit er, bit ee, string tag);
        @(negedge clk);
        rx_code = c;
        @(posedge clk); #1;
        chk(rx_dv === dv, {tag, " dv"}, 32'(rx_dv), 32'(dv));
        chk(rx_er === er, {tag, " er"}, 32'(rx_er), 32'(er));
        chk(rx_early_end === ee, {tag, " early_end"}, 32'(rx_early_end), 32'(ee));
        if (dv && !er) chk(rx_nib === nib, {tag, " nib"}, 32'(rx_nib), 32'(nib));
    endtask

    // Sends one frame of len nibbles; er_pct is the chance of tx_er per data nibble.
    task automatic tx_frame(int len, int er_pct);
        for (int i = 0; i < len; i++) begin
            logic [3:0] n;
            bit e;
            n = 4'($urandom_range(15, 0));
            e = ($urandom_range(99, 0) < er_pct);
            @(negedge clk);
            tx_en = 1'b1; tx_nib = n; tx_er = e;
            @(posedge clk); #1;
            if (i == 0)      tx_chk(C_J, "R3 start J");
            else if (i == 1) tx_chk(C_K, "R3 start K");
            else if (e)      tx_chk(C_HALT, "R6 halt");
            else             tx_chk(exp_enc(n), "R4 data");
        end
        @(negedge clk); tx_en = 1'b0; tx_er = 1'b0;
        @(posedge clk); #1; tx_chk(C_T, "R5 end T");
        @(negedge clk);
        @(posedge clk); #1; tx_chk(C_R, "R5 end R");
        @(negedge clk);
        @(posedge clk); #1; tx_chk(C_IDLE, "R2 idle after R");
    endtask

    // Receive frame with random data and occasional invalid groups.
    task automatic rx_frame(int len, int bad_pct);
        rx_step(C_J, 0, 0, 0, 0, "R7 J");
        rx_step(C_K, 0, 0, 0, 0, "R7 K");
        for (int i = 0; i < len; i++) begin
            if ($urandom_range(99, 0) < bad_pct) begin
                logic [4:0] c;
                do c = 5'($urandom_range(31, 0));
                while (is_data(c) || c == C_T || c == C_IDLE);
                rx_step(c, 1, 0, 1, 0, "R9 invalid");
            end else begin
                logic [3:0] n;
                n = 4'($urandom_range(15, 0));
                rx_step(exp_enc(n), 1, n, 0, 0, "R7 data");
            end
        end
        rx_step(C_T, 0, 0, 0, 0, "R8 T");
        rx_step(C_R, 0, 0, 0, 0, "R8 R");
    endtask

    initial begin
        #(8 * 200000);
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        chk(tx_code === C_IDLE, "R1 tx reset", 32'(tx_code), 32'(C_IDLE));
        chk(!rx_dv && !rx_er && !rx_early_end, "R1 rx reset",
            32'({rx_dv, rx_er, rx_early_end}), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) begin
            @(posedge clk); #1; tx_chk(C_IDLE, "R2 idle gap");
        end

        // Directed: tx_er on the start nibbles is ignored, shortest frame.
        @(negedge clk); tx_en = 1; tx_er = 1; tx_nib = 4'h3;
        @(posedge clk); #1; tx_chk(C_J, "R3 J despite er");
        @(negedge clk);
        @(posedge clk); #1; tx_chk(C_K, "R3 K despite er");
        @(negedge clk); tx_er = 0; tx_nib = 4'hF;
        @(posedge clk); #1; tx_chk(exp_enc(4'hF), "R4 nib F");
        @(negedge clk); tx_en = 0;
        @(posedge clk); #1; tx_chk(C_T, "R5 T short");
        @(negedge clk); tx_en = 1; tx_nib = 4'h0;
        @(posedge clk); #1; tx_chk(C_R, "R5 R despite new en");
        @(negedge clk);
        @(posedge clk); #1; tx_chk(C_J, "R3 back-to-back J");
        @(negedge clk); tx_en = 0;
        @(posedge clk); #1; tx_chk(C_K, "R3 K after early drop");
        @(negedge clk);
        @(posedge clk); #1; tx_chk(C_T, "R5 T after K");
        @(negedge clk);
        @(posedge clk); #1; tx_chk(C_R, "R5 R after K");
        @(negedge clk);
        @(posedge clk); #1; tx_chk(C_IDLE, "R2 idle");

        // Full code table sweep.
        @(negedge clk); tx_en = 1;
        @(posedge clk); @(negedge clk);
        @(posedge clk);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); tx_nib = 4'(i);
            @(posedge clk); #1; tx_chk(exp_enc(4'(i)), "R4 table");
        end
        @(negedge clk); tx_en = 0;
        repeat (3) @(posedge clk);

        // Random transmit frames.
        for (int f = 0; f < 25; f++) begin
            tx_frame($urandom_range(18, 3), 10);
            repeat ($urandom_range(3, 0)) begin
                @(posedge clk); #1; tx_chk(C_IDLE, "R2 random gap");
            end
        end

        // Receive directed cases.
        rx_step(exp_enc(4'h5), 0, 0, 0, 0, "R7 data while hunting");
        rx_step(C_J, 0, 0, 0, 0, "R7 lone J");
        rx_step(exp_enc(4'h5), 0, 0, 0, 0, "R7 J without K");
        rx_step(C_J, 0, 0, 0, 0, "R7 J");
        rx_step(C_J, 0, 0, 0, 0, "R7 J repeat");
        rx_step(C_K, 0, 0, 0, 0, "R7 K");
        rx_step(exp_enc(4'hA), 1, 4'hA, 0, 0, "R7 data A");
        rx_step(C_HALT, 1, 0, 1, 0, "R9 halt");
        rx_step(C_R, 1, 0, 1, 0, "R9 R in frame");
        rx_step(C_T, 0, 0, 0, 0, "R8 T");
        rx_step(C_R, 0, 0, 0, 0, "R8 R no error");
        rx_step(exp_enc(4'h7), 0, 0, 0, 0, "R8 data after close");
        rx_step(C_J, 0, 0, 0, 0, "R8 reopen J");
        rx_step(C_K, 0, 0, 0, 0, "R8 reopen K");
        rx_step(exp_enc(4'h1), 1, 4'h1, 0, 0, "R7 data 1");
        rx_step(C_T, 0, 0, 0, 0, "R8 T");
        rx_step(C_IDLE, 0, 0, 1, 0, "R8 T without R");
        rx_step(exp_enc(4'h2), 0, 0, 0, 0, "R8 closed after bad end");
        rx_step(C_J, 0, 0, 0, 0, "R10 J");
        rx_step(C_K, 0, 0, 0, 0, "R10 K");
        rx_step(exp_enc(4'h9), 1, 4'h9, 0, 0, "R10 data");
        rx_step(C_IDLE, 0, 0, 0, 0, "R10 single idle");
        rx_step(exp_enc(4'hC), 1, 4'hC, 0, 0, "R10 resume after one idle");
        rx_step(C_IDLE, 0, 0, 0, 0, "R10 first idle");
        rx_step(C_IDLE, 0, 0, 0, 1, "R10 second idle");
        rx_step(exp_enc(4'h3), 0, 0, 0, 0, "R10 closed");

        for (int f = 0; f < 25; f++) rx_frame($urandom_range(12, 1), 12);

        // Parallel: transmit end delimiters against a faulty receive frame.
        fork
            tx_frame(6, 0);
            begin
                rx_step(C_J, 0, 0, 0, 0, "R7 J par");
                rx_step(C_K, 0, 0, 0, 0, "R7 K par");
                rx_step(exp_enc(4'h4), 1, 4'h4, 0, 0, "R7 data par");
                rx_step(5'b00000, 1, 0, 1, 0, "R9 invalid par");
                rx_step(exp_enc(4'hE), 1, 4'hE, 0, 0, "R7 data par");
                rx_step(C_IDLE, 0, 0, 0, 0, "R10 idle par");
                rx_step(C_IDLE, 0, 0, 0, 1, "R10 early end par");
                rx_step(C_IDLE, 0, 0, 0, 0, "R10 quiet par");
            end
        join

        // Bypass via the register bit.
        @(negedge clk); cfg_bypass = 1; tx_raw = 5'h0A; rx_code = C_J;
        @(posedge clk); #1;
        tx_chk(5'h0A, "R11 cfg raw tx");
        chk(rx_raw === C_J, "R12 raw rx", 32'(rx_raw), 32'(C_J));
        rx_step(C_K, 0, 0, 0, 0, "R11 K in bypass");
        rx_step(exp_enc(4'h6), 0, 0, 0, 0, "R11 data in bypass");
        chk(rx_raw === exp_enc(4'h6), "R12 raw rx data", 32'(rx_raw), 32'(exp_enc(4'h6)));
        @(negedge clk); cfg_bypass = 0; strap_bypass = 1; tx_raw = 5'h13;
        @(posedge clk); #1; tx_chk(5'h13, "R11 strap raw tx");
        @(negedge clk); strap_bypass = 0;
        @(posedge clk); #1; tx_chk(C_IDLE, "R11 idle after bypass");

        // Bypass raised inside frames on both sides.
        @(negedge clk); tx_en = 1; tx_nib = 4'h8; rx_code = C_J;
        @(posedge clk); #1; tx_chk(C_J, "R3 J");
        @(negedge clk); rx_code = C_K;
        @(posedge clk); #1; tx_chk(C_K, "R3 K");
        @(negedge clk); rx_code = exp_enc(4'h8);
        @(posedge clk); #1; tx_chk(exp_enc(4'h8), "R4 data 8");
        chk(rx_dv === 1'b1, "R7 dv before bypass", 32'(rx_dv), 1);
        @(negedge clk); strap_bypass = 1; tx_raw = 5'h01;
        @(posedge clk); #1; tx_chk(5'h01, "R11 mid-frame raw");
        chk(rx_dv === 1'b0, "R11 dv in bypass", 32'(rx_dv), 0);
        @(negedge clk); strap_bypass = 0;
        @(posedge clk); #1; tx_chk(C_J, "R11 tx restarts with J");
        chk(rx_dv === 1'b0, "R11 rx framing reset", 32'(rx_dv), 0);
        @(negedge clk); tx_en = 0;
        repeat (4) @(posedge clk);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule